// File: doc/BRIEF.md
# Fuse Word Permanent Lock Sequencer

This block drives a one-time-programmable fuse controller through the steps needed to make one fuse word permanently write-locked. A requester hands it an option word and a fuse index. If the permanent-lock option is clear, the request finishes at once with nothing to do. If the index is outside the array, the request is rejected. Otherwise the sequencer works out which lock word and which bits belong to that index, switches the fuse memory on if it was off, and writes the data word followed by a combined write-and-lock command. It then waits for the controller to go idle, reads the failure and error flags, switches the memory back off if it switched it on, and reports one status code.

The controller side is a small register-style port: a write strobe, a register select and a 32-bit data word, plus status levels for power, busy, programming failure and per-index error. A separate combinational query port returns the permanent write-lock state of any fuse word from the controller's lock bit vector.

Top module: `otp_lock_seq`

## Requirements
- R1: A request whose option bit 0 is 0 finishes with status 0 (success) on the cycle after acceptance, with no controller write.
- R2: A request with option bit 0 set and an index of 96 or more finishes with status 1 (invalid) on the cycle after acceptance, with no controller write.
- R3: For an index below 32 the data word is 3 shifted left by twice (index mod 8), and the lock word address is index divided by 8; bits 31:16 of a data write are always 0.
- R4: For an index from 32 to 95 the data word is 1 shifted left by (index mod 16), and the lock word address is 4 plus (index minus 32) divided by 16.
- R5: Register select codes are 0 for data, 1 for command, 2 for power; the data write comes on the cycle just before the command write, and the command word is the address OR 0x100 (write) OR 0x200 (lock).
- R6: If the power status is low when the operation starts, the sequencer writes 1 to the power register, waits for power, and writes 0 to it before finishing, whatever the result; if the power is already on it makes no power write.
- R7: The sequencer waits for busy to go low after the command; if it stays high for TIMEOUT_CYC cycles the status is 3 (timeout).
- R8: After busy clears, a set programming-failure flag gives status 2 (denied); otherwise a set error flag gives status 4 (check error); otherwise status 0.
- R9: The query output is 1 in bit 0 when the lock bit of the queried index is set, and 0 otherwise, including for indices of 96 or more.
- R10: A request is accepted only while ready is high; requests presented while an operation runs are ignored, and each accepted request gives exactly one single-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_opt | input | 32 | Option word; bit 0 asks for a permanent lock |
| req_idx | input | 7 | Fuse word index |
| req_ready | output | 1 | High while idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code, valid with done and held afterwards |
| ctl_wr | output | 1 | Controller register write strobe |
| ctl_sel | output | 2 | Controller register select |
| ctl_wdata | output | 32 | Controller write data |
| ctl_pwr_on | input | 1 | Fuse memory powered |
| ctl_busy | input | 1 | Controller operation in progress |
| ctl_progfail | input | 1 | Programming failure flag |
| ctl_err | input | 1 | Error flag for the current index |
| lk_vec | input | 96 | Permanent write-lock bit per fuse word |
| qry_idx | input | 7 | Index to query |
| qry_val | output | 32 | Lock status of the queried index |

## Verification
The assertions assume that the controller raises busy on the edge of the command write or later, and that the failure and error flags are steady while the sequencer samples them. They also assume the power status changes only in answer to a power register write. The bench's controller model sets busy on the command edge and drops it after a programmable latency, turns power on two cycles after a power-up write and off at once on a power-down write, and holds the failure and error flags fixed for the whole of each request.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;

  typedef enum logic [2:0] {
    LK_OK      = 3'd0,
    LK_INVAL   = 3'd1,
    LK_DENIED  = 3'd2,
    LK_TMO     = 3'd3,
    LK_CHKERR  = 3'd4
  } lk_status_e;

  typedef enum logic [1:0] {
    SEL_WDATA = 2'd0,
    SEL_CMD   = 2'd1,
    SEL_PWR   = 2'd2
  } ctl_sel_e;

  localparam logic [31:0] CMD_WRITE = 32'h0000_0100;
  localparam logic [31:0] CMD_LOCK  = 32'h0000_0200;

  // Lock word address: lower words pack two bits each, upper words one bit each.
  function automatic logic [31:0] lock_word_addr(input int unsigned idx,
                                                 input int unsigned upper_start,
                                                 input int unsigned data_w);
    int unsigned lo_per;
    lo_per = data_w / 2;
    if (idx < upper_start) return idx / lo_per;
    return (upper_start / lo_per) + (idx - upper_start) / data_w;
  endfunction

  // Lock bit pattern inside the data word.
  function automatic logic [31:0] lock_word_bits(input int unsigned idx,
                                                 input int unsigned upper_start,
                                                 input int unsigned data_w);
    int unsigned sh;
    if (idx < upper_start) begin
      sh = (idx * 2) % data_w;
      return 32'd3 << sh;
    end
    sh = idx % data_w;
    return 32'd1 << sh;
  endfunction

endpackage

// File: rtl/otp_lock_map.sv
module otp_lock_map
  import otp_lock_pkg::*;
#(
  parameter int unsigned UPPER_START = 32,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned IDX_W       = 7
) (
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      addr,
  output logic [31:0]      bits
);
  always_comb begin
    addr = lock_word_addr(int'(idx), UPPER_START, DATA_W);
    bits = lock_word_bits(int'(idx), UPPER_START, DATA_W);
  end
endmodule

// File: rtl/otp_lock_timer.sv
module otp_lock_timer #(
  parameter int unsigned LIMIT = 64,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic first,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expired)  cnt <= cnt + CW'(1);
  end

  assign first   = (cnt == '0);
  assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/otp_lock_query.sv
module otp_lock_query #(
  parameter int unsigned NUM_WORDS = 96,
  parameter int unsigned IDX_W     = 7
) (
  input  logic [NUM_WORDS-1:0] lk_vec,
  input  logic [IDX_W-1:0]     idx,
  output logic [31:0]          val
);
  always_comb begin
    val = '0;
    for (int i = 0; i < int'(NUM_WORDS); i++) begin
      if (int'(idx) == i) val[0] = lk_vec[i];
    end
  end
endmodule

// File: rtl/otp_lock_seq.sv
module otp_lock_seq
  import otp_lock_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 96,
  parameter int unsigned UPPER_START = 32,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TIMEOUT_CYC = 64,
  localparam int unsigned IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          req_opt,
  input  logic [IDX_W-1:0]     req_idx,
  output logic                 req_ready,
  output logic                 done,
  output logic [2:0]           status,
  output logic                 ctl_wr,
  output logic [1:0]           ctl_sel,
  output logic [31:0]          ctl_wdata,
  input  logic                 ctl_pwr_on,
  input  logic                 ctl_busy,
  input  logic                 ctl_progfail,
  input  logic                 ctl_err,
  input  logic [NUM_WORDS-1:0] lk_vec,
  input  logic [IDX_W-1:0]     qry_idx,
  output logic [31:0]          qry_val
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_PWRUP, S_PWRWT, S_DATA, S_CMD, S_BUSY, S_PWRDN, S_FIN
  } seq_state_e;

  seq_state_e  state, state_n;
  logic [IDX_W-1:0] idx_q;
  logic        own_pwr;
  lk_status_e  stat_q, stat_n;
  logic [31:0] map_addr, map_bits;
  logic        tmr_run, tmr_first, tmr_exp;

  // Named internal events for the checker.
  logic acc_ev, cmd_ev, pwrup_ev, pwrdn_ev, busy_done_ev;

  otp_lock_map #(.UPPER_START(UPPER_START), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_map (
    .idx(idx_q), .addr(map_addr), .bits(map_bits)
  );

  otp_lock_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .first(tmr_first), .expired(tmr_exp)
  );

  otp_lock_query #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_qry (
    .lk_vec(lk_vec), .idx(qry_idx), .val(qry_val)
  );

  assign req_ready    = (state == S_IDLE);
  assign acc_ev       = req_ready && req_valid;
  assign tmr_run      = (state == S_PWRWT) || (state == S_BUSY);
  assign busy_done_ev = (state == S_BUSY) && !tmr_first && !ctl_busy;
  assign cmd_ev       = (state == S_CMD);
  assign pwrup_ev     = (state == S_PWRUP);
  assign pwrdn_ev     = (state == S_PWRDN);
  assign done         = (state == S_FIN);
  assign status       = stat_q;

  always_comb begin
    state_n = state;
    stat_n  = stat_q;
    unique case (state)
      S_IDLE: if (acc_ev) begin
        if (!req_opt[0]) begin
          state_n = S_FIN; stat_n = LK_OK;
        end else if (int'(req_idx) >= int'(NUM_WORDS)) begin
          state_n = S_FIN; stat_n = LK_INVAL;
        end else begin
          state_n = S_CHK;
        end
      end
      S_CHK:   state_n = ctl_pwr_on ? S_DATA : S_PWRUP;
      S_PWRUP: state_n = S_PWRWT;
      S_PWRWT: begin
        if (ctl_pwr_on) state_n = S_DATA;
        else if (tmr_exp) begin state_n = S_PWRDN; stat_n = LK_TMO; end
      end
      S_DATA:  state_n = S_CMD;
      S_CMD:   state_n = S_BUSY;
      S_BUSY: begin
        if (busy_done_ev) begin
          state_n = own_pwr ? S_PWRDN : S_FIN;
          if (ctl_progfail)  stat_n = LK_DENIED;
          else if (ctl_err)  stat_n = LK_CHKERR;
          else               stat_n = LK_OK;
        end else if (tmr_exp) begin
          state_n = own_pwr ? S_PWRDN : S_FIN;
          stat_n  = LK_TMO;
        end
      end
      S_PWRDN: state_n = S_FIN;
      S_FIN:   state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stat_q  <= LK_OK;
      idx_q   <= '0;
      own_pwr <= 1'b0;
    end else begin
      state  <= state_n;
      stat_q <= stat_n;
      if (acc_ev) begin
        idx_q   <= req_idx;
        own_pwr <= 1'b0;
      end
      if (state == S_CHK) own_pwr <= !ctl_pwr_on;
    end
  end

  always_comb begin
    ctl_wr    = 1'b0;
    ctl_sel   = SEL_WDATA;
    ctl_wdata = '0;
    unique case (state)
      S_PWRUP: begin ctl_wr = 1'b1; ctl_sel = SEL_PWR;   ctl_wdata = 32'd1; end
      S_PWRDN: begin ctl_wr = 1'b1; ctl_sel = SEL_PWR;   ctl_wdata = 32'd0; end
      S_DATA:  begin ctl_wr = 1'b1; ctl_sel = SEL_WDATA; ctl_wdata = map_bits; end
      S_CMD:   begin ctl_wr = 1'b1; ctl_sel = SEL_CMD;
                     ctl_wdata = map_addr | CMD_WRITE | CMD_LOCK; end
      default: ;
    endcase
  end

endmodule

// File: rtl/otp_lock_chk.sv
module otp_lock_chk #(
  parameter int unsigned NUM_WORDS = 96,
  parameter int unsigned IDX_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_opt0,
  input logic [IDX_W-1:0] req_idx,
  input logic             req_ready,
  input logic             done,
  input logic [2:0]       status,
  input logic             ctl_wr,
  input logic [1:0]       ctl_sel,
  input logic [31:0]      ctl_wdata,
  input logic             acc_ev,
  input logic             cmd_ev,
  input logic             pwrup_ev,
  input logic             pwrdn_ev
);
  logic own_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)        own_seen <= 1'b0;
    else if (pwrup_ev) own_seen <= 1'b1;
    else if (done)     own_seen <= 1'b0;
  end

  AST_SKIP_NOPERM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev && !req_opt0 |=> done && status == 3'd0 && !ctl_wr); // R1

  AST_REJECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev && req_opt0 && (int'(req_idx) >= int'(NUM_WORDS)) |=> done && status == 3'd1 && !ctl_wr); // R2

  AST_DATA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_sel == 2'd0 |-> ctl_wdata[31:16] == 16'h0); // R3

  AST_CMD_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ev |-> $past(ctl_wr && ctl_sel == 2'd0)); // R5

  AST_CMD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ev |-> ctl_wdata[9:8] == 2'b11 && ctl_wdata[31:10] == 22'h0 && ctl_wdata[7:3] == 5'h0); // R5

  AST_PWRDN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_ev |-> own_seen); // R6

  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R10

endmodule

bind otp_lock_seq otp_lock_chk #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_opt0(req_opt[0]), .req_idx(req_idx),
  .req_ready(req_ready), .done(done), .status(status), .ctl_wr(ctl_wr),
  .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata), .acc_ev(acc_ev), .cmd_ev(cmd_ev),
  .pwrup_ev(pwrup_ev), .pwrdn_ev(pwrdn_ev)
);

// File: tb/tb_otp_lock_seq.sv
module tb_otp_lock_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 64;
  localparam int NW         = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_opt = '0;
  logic [6:0]  req_idx = '0;
  logic        req_ready, done;
  logic [2:0]  status;
  logic        ctl_wr;
  logic [1:0]  ctl_sel;
  logic [31:0] ctl_wdata;
  logic        ctl_pwr_on = 1'b0, ctl_busy = 1'b0;
  logic        ctl_progfail = 1'b0, ctl_err = 1'b0;
  logic [NW-1:0] lk_vec = '0;
  logic [6:0]  qry_idx = '0;
  logic [31:0] qry_val;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_lock_seq #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opt(req_opt),
    .req_idx(req_idx), .req_ready(req_ready), .done(done), .status(status),
    .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .ctl_pwr_on(ctl_pwr_on), .ctl_busy(ctl_busy), .ctl_progfail(ctl_progfail),
    .ctl_err(ctl_err), .lk_vec(lk_vec), .qry_idx(qry_idx), .qry_val(qry_val)
  );

  // Controller model
  int n_wr = 0, lat_cnt = 0, pend = 0, busy_lat = 2;
  bit busy_stuck = 0, pwr_stb = 0, pwr_val = 0;
  logic [31:0] m_wdata = '0, m_cmd = '0;

  always @(posedge clk) begin
    if (pwr_stb) ctl_pwr_on <= pwr_val;
    if (ctl_busy && !busy_stuck) begin
      if (lat_cnt == 0) ctl_busy <= 1'b0;
      else lat_cnt <= lat_cnt - 1;
    end
    if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) ctl_pwr_on <= 1'b1;
    end
    if (ctl_wr) begin
      n_wr <= n_wr + 1;
      case (ctl_sel)
        2'd0: m_wdata <= ctl_wdata;
        2'd1: begin m_cmd <= ctl_wdata; ctl_busy <= 1'b1; lat_cnt <= busy_lat; end
        2'd2: if (ctl_wdata[0]) pend <= 2; else ctl_pwr_on <= 1'b0;
        default: ;
      endcase
    end
  end

  typedef struct {
    logic [2:0]  st;
    logic [31:0] wdata;
    logic [31:0] cmd;
    int          nwr;
    int          base;
    bit          pwr_end;
    string       rq_st;
    string       rq_map;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(bit ok, string rq, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, expv);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(status == e.st, e.rq_st, "status", status, e.st);
        check((n_wr - e.base) == e.nwr, "R6", "write count", n_wr - e.base, e.nwr);
        check(ctl_pwr_on == e.pwr_end, "R6", "power at end", ctl_pwr_on, e.pwr_end);
        if (e.nwr > 0) begin
          check(m_wdata == e.wdata, e.rq_map, "data word", m_wdata, e.wdata);
          check(m_cmd == e.cmd, "R5", "command word", m_cmd, e.cmd);
        end
      end
    end
  end

  task automatic set_power(bit on);
    @(negedge clk); pwr_val = on; pwr_stb = 1;
    @(negedge clk); pwr_stb = 0;
  endtask

  task automatic send(int idx, logic [31:0] opt, bit pwr_off, bit stuck,
                      bit pf, bit er, int lat, string rq);
    exp_t e;
    int a;
    set_power(!pwr_off);
    busy_stuck = stuck; ctl_progfail = pf; ctl_err = er; busy_lat = lat;
    e.base = n_wr;
    e.pwr_end = !pwr_off;
    e.rq_st = rq;
    if (idx < 32) begin
      a = idx >> 3;
      e.wdata = 32'd3 << (2 * (idx % 8));
      e.rq_map = "R3";
    end else begin
      a = 4 + (idx - 32) / 16;
      e.wdata = 32'd1 << (idx % 16);
      e.rq_map = "R4";
    end
    e.cmd = 32'h300 + a;
    if (!opt[0])          begin e.st = 3'd0; e.nwr = 0; end
    else if (idx >= NW)   begin e.st = 3'd1; e.nwr = 0; end
    else begin
      e.nwr = pwr_off ? 4 : 2;
      if (stuck)    e.st = 3'd3;
      else if (pf)  e.st = 3'd2;
      else if (er)  e.st = 3'd4;
      else          e.st = 3'd0;
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    exp_q.push_back(e);
    req_valid = 1; req_opt = opt; req_idx = 7'(idx);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    busy_stuck = 0;
    repeat (busy_lat + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "R10", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R10", "reset ready", req_ready, 1);
    check(done == 0, "R10", "reset done", done, 0);
    check(ctl_wr == 0, "R1", "reset write strobe", ctl_wr, 0);

    send(5,  32'h0, 1, 0, 0, 0, 2, "R1"); drain();           // R1 no-perm option
    send(7,  32'h1, 0, 0, 0, 0, 2, "R2"); drain();           // below range boundary: valid
    send(100, 32'h1, 0, 0, 0, 0, 2, "R2"); drain();          // R2 invalid index
    send(96, 32'h1, 1, 0, 0, 0, 2, "R2"); drain();           // R2 boundary
    send(0,  32'h1, 0, 0, 0, 0, 1, "R3"); drain();           // R3 lowest
    send(13, 32'h1, 1, 0, 0, 0, 3, "R3"); drain();           // R3 with power up, R6
    send(31, 32'h1, 0, 0, 0, 0, 0, "R3"); drain();           // R3 top of lower
    send(32, 32'h1, 0, 0, 0, 0, 2, "R4"); drain();           // R4 first upper
    send(61, 32'h1, 1, 0, 0, 0, 5, "R4"); drain();           // R4, R6
    send(95, 32'h1, 0, 0, 0, 0, 2, "R4"); drain();           // R4 last
    send(40, 32'h1, 0, 0, 1, 0, 2, "R8"); drain();           // R8 denied
    send(41, 32'h1, 1, 0, 0, 1, 2, "R8"); drain();           // R8 check error, R6
    send(42, 32'h1, 0, 0, 1, 1, 2, "R8"); drain();           // R8 priority
    send(20, 32'h1, 1, 1, 0, 0, 2, "R7"); drain();           // R7 timeout, power restored
    send(21, 32'h1, 0, 1, 0, 0, 2, "R7"); drain();           // R7 timeout, power kept
    send(50, 32'h1, 0, 0, 0, 0, TMO - 4, "R7"); drain();     // R7 long busy below limit

    // R10: requests during an operation are ignored
    send(9, 32'h1, 0, 0, 0, 0, 20, "R10");
    repeat (4) begin
      @(negedge clk);
      req_valid = 1; req_opt = 32'h1; req_idx = 7'd70;
    end
    @(negedge clk); req_valid = 0;
    drain();
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R10", "queue empty", exp_q.size(), 0);

    // R9 query port
    lk_vec = '0; lk_vec[3] = 1'b1; lk_vec[70] = 1'b1;
    qry_idx = 7'd3;   #1 check(qry_val == 32'd1, "R9", "query idx3", qry_val, 1);
    qry_idx = 7'd4;   #1 check(qry_val == 32'd0, "R9", "query idx4", qry_val, 0);
    qry_idx = 7'd70;  #1 check(qry_val == 32'd1, "R9", "query idx70", qry_val, 1);
    qry_idx = 7'd100; #1 check(qry_val == 32'd0, "R9", "query idx100", qry_val, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule